// File: doc/BRIEF.md
# Sliding-Window Running Median

This block is a running median over the most recent `N` samples. It keeps the window as a row of value cells that stays sorted, so the median is always the value held in the middle cell. Each cell also has a link field. The link names the cell that holds the next-younger sample, which makes the cells an age-ordered linked list. Two pointers mark the oldest sample and the newest sample.

Each accepted sample goes through two fixed phases.

- **Evict phase.** When the window is full, the cell named by the oldest-sample pointer is removed. The cells above it move down one place, and any link that pointed past it is decremented.
- **Insert phase.** Every live cell compares its value with the new sample. The resulting thermometer code is encoded into an insertion index. Cells at or above that index move up one place, their links are adjusted, and the newest-sample pointer moves to the new cell.

Until `N` samples have arrived, nothing is evicted and no median is reported. A sample is taken only while the block is idle. Samples must therefore be at least three cycles apart.

Top module: `sw_median`

## Requirements
- R1: After synchronous reset, `med_valid` is low and the window is empty. A reset in the middle of a stream discards every stored sample, and the fill starts again.
- R2: When `med_valid` is high, `med_out` equals the element at rank `N/2`, counting from rank 0, of the last `N` accepted samples sorted in ascending order.
- R3: While fewer than `N` samples have been accepted since reset, `med_valid` stays low. The first pulse follows the `N`-th sample.
- R4: An accepted sample produces `med_valid` high in exactly one cycle. That cycle follows the third rising edge counted from the edge that sampled `in_valid`. The signal is low again on the next cycle.
- R5: `in_valid` is ignored while the block is still processing the previous sample. The ignored value never enters the window.
- R6: Duplicate sample values are stored and evicted individually. The median stays correct when the window holds repeated values.
- R7: Once the window is full, each new sample evicts the oldest stored sample, whatever its value. While the window is filling, nothing is evicted.
- R8: The window size `N` is an odd parameter of at least 3. The link and pointer width is `ceil(log2 N)`, and the occupancy never exceeds `N`.
- R9: Between updates, the live cells are in non-decreasing order, and both pointers name live cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe, taken only when idle |
| in_data | input | W | Unsigned sample value |
| med_out | output | W | Value held in the middle cell |
| med_valid | output | 1 | One-cycle pulse: `med_out` is the median of the current window |

## Verification
A corrupted link or pointer shows up as the wrong sample being evicted. The median therefore drifts from the reference only once that sample should have left, which can take up to `N` samples. For that reason the stimulus runs well past two full windows and includes monotonic runs, where the age order and the value order are the same or opposite. A broken shift or a mis-encoded insertion index breaks the sort order. That shows up at the very next pulse, and the ordering check inside the block catches it on the same update. Repeated values expose comparator ties that place the new sample on the wrong side of an equal one.

// File: rtl/med_pkg.sv
package med_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_EVICT, ST_INSERT} med_state_e;

  // Position of a link after the cell at index gone is removed.
  function automatic int link_after_evict(int link, int gone);
    return (link > gone) ? link - 1 : link;
  endfunction

  // Position of a link after a new cell is opened at index slot.
  function automatic int link_after_insert(int link, int slot);
    return (link >= slot) ? link + 1 : link;
  endfunction
endpackage

// File: rtl/med_therm_enc.sv
module med_therm_enc #(
  parameter int N  = 101,
  parameter int LW = 7
) (
  input  logic [N-1:0]  ge,
  output logic [LW-1:0] pos
);
  // ge is 1..1 0..0 from index 0 upward; pos is the index of the first zero.
  always_comb begin
    pos = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ge[i]) pos = LW'(i);
    end
  end
endmodule

// File: rtl/med_cell.sv
module med_cell
  import med_pkg::*;
#(
  parameter int W   = 14,
  parameter int LW  = 7,
  parameter int N   = 101,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evict_do,
  input  logic          insert_do,
  input  logic          live,
  input  logic          has_tail,
  input  logic [LW-1:0] hd,
  input  logic [LW-1:0] ins_p,
  input  logic [LW-1:0] tl,
  input  logic [W-1:0]  x,
  input  logic [W-1:0]  lo_v,
  input  logic [LW-1:0] lo_l,
  input  logic [W-1:0]  hi_v,
  input  logic [LW-1:0] hi_l,
  output logic [W-1:0]  v_q,
  output logic [LW-1:0] l_q,
  output logic          ge
);
  logic [W-1:0]  v_d, sv;
  logic [LW-1:0] l_d, sl;
  int            sidx;

  assign ge = live && (v_q <= x);

  always_comb begin
    v_d  = v_q;
    l_d  = l_q;
    sv   = v_q;
    sl   = l_q;
    sidx = IDX;
    if (evict_do) begin
      if (IDX >= int'(hd) && IDX < N - 1) begin
        sv = hi_v;
        sl = hi_l;
      end
      v_d = sv;
      l_d = LW'(link_after_evict(int'(sl), int'(hd)));
    end else if (insert_do) begin
      if (IDX > int'(ins_p)) begin
        sv   = lo_v;
        sl   = lo_l;
        sidx = IDX - 1;
      end
      if (IDX == int'(ins_p)) begin
        v_d = x;
        l_d = '0;
      end else begin
        v_d = sv;
        l_d = (has_tail && sidx == int'(tl)) ? ins_p
                                             : LW'(link_after_insert(int'(sl), int'(ins_p)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      l_q <= '0;
    end else begin
      v_q <= v_d;
      l_q <= l_d;
    end
  end
endmodule

// File: rtl/med_ctrl.sv
module med_ctrl
  import med_pkg::*;
#(
  parameter int W  = 14,
  parameter int N  = 101,
  parameter int LW = 7,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic [LW-1:0] ins_p,
  input  logic [LW-1:0] head_link,
  output logic [W-1:0]  smp,
  output logic [LW-1:0] head,
  output logic [LW-1:0] tail,
  output logic [CW-1:0] cnt,
  output logic          evict_do,
  output logic          insert_do,
  output logic          med_valid
);
  med_state_e st;
  logic       full;

  assign full      = (int'(cnt) == N);
  assign evict_do  = (st == ST_EVICT) && full;
  assign insert_do = (st == ST_INSERT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      smp       <= '0;
      head      <= '0;
      tail      <= '0;
      cnt       <= '0;
      med_valid <= 1'b0;
    end else begin
      med_valid <= 1'b0;
      case (st)
        ST_IDLE: if (in_valid) begin
          smp <= in_data;
          st  <= ST_EVICT;
        end
        ST_EVICT: begin
          if (full) begin
            head <= LW'(link_after_evict(int'(head_link), int'(head)));
            tail <= LW'(link_after_evict(int'(tail), int'(head)));
            cnt  <= cnt - 1'b1;
          end
          st <= ST_INSERT;
        end
        default: begin
          tail      <= ins_p;
          head      <= (cnt == '0) ? ins_p
                                   : LW'(link_after_insert(int'(head), int'(ins_p)));
          cnt       <= cnt + 1'b1;
          med_valid <= (int'(cnt) + 1 == N);
          st        <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sw_median.sv
module sw_median #(
  parameter int W = 14,
  parameter int N = 101
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] med_out,
  output logic         med_valid
);
  localparam int LW  = $clog2(N);
  localparam int CW  = $clog2(N + 1);
  localparam int MID = N / 2;

  logic [W-1:0]  val  [N];
  logic [LW-1:0] lnk  [N];
  logic [W-1:0]  vpad [N+2];
  logic [LW-1:0] lpad [N+2];
  logic [N-1:0]  ge;
  logic [N-2:0]  le_pair;
  logic [LW-1:0] ins_p, head, tail, head_link;
  logic [CW-1:0] cnt;
  logic [W-1:0]  smp;
  logic          evict_do, insert_do;

  initial begin
    if (N < 3 || (N % 2) == 0) $error("window size must be odd and at least 3");
  end

  assign head_link = lnk[head];
  assign med_out   = val[MID];

  assign vpad[0]   = '0;
  assign lpad[0]   = '0;
  assign vpad[N+1] = '0;
  assign lpad[N+1] = '0;

  for (genvar i = 0; i < N; i++) begin : g_cell
    assign vpad[i+1] = val[i];
    assign lpad[i+1] = lnk[i];
    med_cell #(.W(W), .LW(LW), .N(N), .IDX(i)) cell_i (
      .clk      (clk),
      .rst      (rst),
      .evict_do (evict_do),
      .insert_do(insert_do),
      .live     (i < int'(cnt)),
      .has_tail (cnt != '0),
      .hd       (head),
      .ins_p    (ins_p),
      .tl       (tail),
      .x        (smp),
      .lo_v     (vpad[i]),
      .lo_l     (lpad[i]),
      .hi_v     (vpad[i+2]),
      .hi_l     (lpad[i+2]),
      .v_q      (val[i]),
      .l_q      (lnk[i]),
      .ge       (ge[i])
    );
  end

  for (genvar i = 0; i < N - 1; i++) begin : g_pair
    assign le_pair[i] = (val[i] <= val[i+1]);
  end

  med_therm_enc #(.N(N), .LW(LW)) enc_i (
    .ge (ge),
    .pos(ins_p)
  );

  med_ctrl #(.W(W), .N(N), .LW(LW), .CW(CW)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .ins_p    (ins_p),
    .head_link(head_link),
    .smp      (smp),
    .head     (head),
    .tail     (tail),
    .cnt      (cnt),
    .evict_do (evict_do),
    .insert_do(insert_do),
    .med_valid(med_valid)
  );
endmodule

// File: rtl/med_chk.sv
module med_chk #(
  parameter int N  = 101,
  parameter int LW = 7,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          evict_do,
  input logic          insert_do,
  input logic          med_valid,
  input logic [CW-1:0] cnt,
  input logic [LW-1:0] head,
  input logic [LW-1:0] tail,
  input logic [N-2:0]  le_pair
);
  logic ord_ok;

  always_comb begin
    ord_ok = 1'b1;
    for (int i = 0; i < N - 1; i++) begin
      if (i + 1 < int'(cnt) && !le_pair[i]) ord_ok = 1'b0;
    end
  end

  AST_ORDERED: assert property (@(posedge clk) disable iff (rst)
    (!evict_do && !insert_do) |-> ord_ok);                                 // R9
  AST_PTR_LIVE: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> (int'(head) < int'(cnt) && int'(tail) < int'(cnt)));   // R9
  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= N);                                                       // R8
  AST_ROOM_ON_INSERT: assert property (@(posedge clk) disable iff (rst)
    insert_do |-> int'(cnt) < N);                                          // R7
  AST_EVICT_THEN_INSERT: assert property (@(posedge clk) disable iff (rst)
    evict_do |=> insert_do);                                               // R7
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    med_valid |=> !med_valid);                                             // R4
  AST_VALID_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    med_valid |-> int'(cnt) == N);                                         // R3
endmodule

bind sw_median med_chk #(.N(N), .LW(LW), .CW(CW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .evict_do (evict_do),
  .insert_do(insert_do),
  .med_valid(med_valid),
  .cnt      (cnt),
  .head     (head),
  .tail     (tail),
  .le_pair  (le_pair)
);

// File: tb/sw_median_tb_top.sv
module sw_median_tb_top;
  localparam int W   = 14;
  localparam int WIN = 7;
  localparam int NS  = 24;
  localparam logic [W-1:0] STIM [NS] = '{
    14'd500, 14'd20, 14'd16383, 14'd7, 14'd300, 14'd300, 14'd42,
    14'd1000, 14'd0, 14'd300, 14'd9999, 14'd5, 14'd5, 14'd5,
    14'd1, 14'd2, 14'd3, 14'd4, 14'd6, 14'd8, 14'd10,
    14'd12000, 14'd11000, 14'd10000
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] med_out;
  logic         med_valid;

  int checks = 0;
  int fails  = 0;
  int hist [512];
  int hn = 0;

  always #2.5 clk = ~clk;

  sw_median #(.W(W), .N(WIN)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .med_out  (med_out),
    .med_valid(med_valid)
  );

  function automatic int ref_median();
    int w [WIN];
    for (int k = 0; k < WIN; k++) w[k] = hist[hn - WIN + k];
    for (int a = 0; a < WIN; a++)
      for (int b = 0; b < WIN - 1 - a; b++)
        if (w[b] > w[b+1]) begin
          int t = w[b]; w[b] = w[b+1]; w[b+1] = t;
        end
    return w[WIN/2];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One sample; optional second strobe while busy (must be ignored, R5).
  task automatic send(input int x, input bit poke, input int junk, input string req);
    @(negedge clk); in_valid = 1'b1; in_data = W'(x);
    hist[hn] = x; hn++;
    @(negedge clk);
    if (poke) in_data = W'(junk); else in_valid = 1'b0;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    if (hn >= WIN) begin
      chk({req, " valid R4"}, int'(med_valid), 1);
      chk({req, " median R2"}, int'(med_out), ref_median());
    end else begin
      chk({req, " fill R3"}, int'(med_valid), 0);
    end
    @(negedge clk);
    chk("R4 pulse width", int'(med_valid), 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset valid", int'(med_valid), 0);

    // Table walk: mixed, duplicates (R6), ascending/descending (R7).
    for (int i = 0; i < NS; i++) send(int'(STIM[i]), 1'b0, 0, "table R6 R7");

    // Busy strobes with extreme values must not enter (R5).
    send(777, 1'b1, 16383, "busy R5");
    send(778, 1'b1, 0, "busy R5");
    send(779, 1'b1, 16383, "busy R5");

    // All equal window (R6).
    for (int i = 0; i < WIN + 2; i++) send(4321, 1'b0, 0, "dup R6");

    // Reset mid-stream restarts fill (R1).
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0; hn = 0;
    @(negedge clk);
    chk("R1 mid reset valid", int'(med_valid), 0);
    for (int i = 0; i < WIN; i++) send(100 * (WIN - i), 1'b0, 0, "refill R1 R3");
    send(16383, 1'b0, 0, "after refill R7");
    send(0, 1'b0, 0, "after refill R7");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule